// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block steps a single switchable power domain between its on and off states in a fixed, safe order. A software-side request port supplies a target level. The sequencer compares that target with the domain's present level. If a change is needed, it turns on the domain clocks one at a time. It then coordinates three things: the bus-interface idle handshake, a separate engine that saves and restores the interconnect's quality-of-service settings, and the power-switch control. Last, it releases the clocks again, highest index first.

Going down, the save and the idle handshake come before the power switch. Coming up, the order is reversed: the switch closes first, the idle request is withdrawn, and the saved settings are restored. Each wait has a programmable cycle limit. If a limit runs out, the run is abandoned with an error flag. Parameters cover domains that have no power switch, no status bit (their on level is read as the inverse of idle status), or no idle handshake.

Top module: `pds_seq`

## Requirements
- R1: When an accepted request already matches the present domain level (on = status input low, or idle status low for a domain without a status bit), the block pulses done on the next cycle. It enables no clock and changes no control output.
- R2: A power-down runs in this order: clocks enabled, save strobe, idle request raised, acknowledge seen high, idle status seen high, power control driven to 1, status seen high, clocks released.
- R3: A power-up runs in this order: clocks enabled, power control driven to 0, status seen low, idle request dropped, acknowledge seen low, idle status seen low, restore strobe, clocks released.
- R4: The status input reads 1 for an off domain and 0 for an on domain. The power control output is 1 to switch the domain off and 0 to switch it on.
- R5: With HAS_STATUS=0, the domain counts as on exactly when its idle status input is low, and no-op decisions follow that level.
- R6: With HAS_IDLE=0, the idle request output never rises. With HAS_PWR=0, the power control output never rises.
- R7: Clock enable bit 0 is turned on first and the highest bit last, one bit per cycle. They are turned off in the reverse order. The enable vector is always a contiguous run of ones starting at bit 0.
- R8: If a wait (save/restore done, acknowledge, idle status, power status) lasts longer than tmo_limit_i cycles, the block sets err_o, pulses done and returns to idle. It takes no further step, so the clocks and controls stay where they are.
- R9: busy_o is high from acceptance until the done cycle. Requests that arrive while busy are dropped. done_o is high for exactly one cycle per accepted request.
- R10: err_o is cleared when the next request is accepted.
- R11: After reset, all clock enables, idle request, power control, busy, done and error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | One-cycle request strobe |
| req_on_i | input | 1 | Requested level: 1 on, 0 off |
| pwr_stat_i | input | 1 | Domain power status, 1 = off |
| idle_ack_i | input | 1 | Bus interface acknowledge of the idle request |
| idle_stat_i | input | 1 | Bus interface idle status |
| qos_done_i | input | 1 | Save/restore engine completion pulse |
| tmo_limit_i | input | TO_W | Cycle limit for every wait |
| clk_en_o | output | NCLK | Domain clock enables |
| idle_req_o | output | 1 | Idle request to the bus interface |
| pwr_off_o | output | 1 | Power switch control, 1 = off |
| qos_save_o | output | 1 | Save start strobe |
| qos_restore_o | output | 1 | Restore start strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last run ended on a timeout |

## Verification
Some properties are checked by assertions on every cycle:
- the clock enables always form a contiguous run of ones;
- a save strobe only fires with every clock enabled;
- the switch only opens while the idle request is held;
- the idle request only drops with the switch closed;
- done is a single-cycle pulse;
- an error can only follow a wait state.

Other behaviour can only be shown by the bench scenarios, which use a reactive domain model. These cover the full step ordering in both directions, the no-op path, the skipped steps for the reduced domain variants, dropped requests while busy, and the frozen state after a timeout together with recovery from it.

// File: rtl/pds_pkg.sv
package pds_pkg;
   typedef enum logic [3:0] {
      S_IDLE,
      S_CLK_UP,
      S_QOS_GO,
      S_QOS_WAIT,
      S_HS_REQ,
      S_HS_ACK,
      S_HS_IDL,
      S_PWR,
      S_PWR_WAIT,
      S_CLK_DN,
      S_DONE
   } pds_state_e;
endpackage

// File: rtl/pds_wait_timer.sv
module pds_wait_timer #(
   parameter int TO_W = 8
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            clr_i,
   input  logic            run_i,
   input  logic [TO_W-1:0] limit_i,
   output logic            expired_o
);
   logic [TO_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         cnt_q <= '0;
      else if (clr_i || !run_i)            cnt_q <= '0;
      else if (cnt_q != limit_i)           cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = run_i && (cnt_q == limit_i);
endmodule

// File: rtl/pds_clk_chain.sv
module pds_clk_chain #(
   parameter int N = 3
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         up_i,
   input  logic         dn_i,
   output logic [N-1:0] en_o,
   output logic         full_o,
   output logic         empty_o
);
   localparam int TOP_IDX = N - 1;

   logic [N-1:0] en_q;

   generate
      if (N == 1) begin : g_single
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)   en_q <= '0;
            else if (up_i) en_q <= 1'b1;
            else if (dn_i) en_q <= 1'b0;
         end
      end else begin : g_multi
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)   en_q <= '0;
            else if (up_i) en_q <= {en_q[TOP_IDX-1:0], 1'b1};
            else if (dn_i) en_q <= {1'b0, en_q[TOP_IDX:1]};
         end
      end
   endgenerate

   assign en_o    = en_q;
   assign full_o  = en_q[TOP_IDX];
   assign empty_o = !en_q[0];

   // R7
   therm_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((en_q + 1'b1) & en_q) == '0);
endmodule

// File: rtl/pds_seq.sv
module pds_seq
   import pds_pkg::*;
#(
   parameter int NCLK       = 3,
   parameter int TO_W       = 8,
   parameter bit HAS_PWR    = 1'b1,
   parameter bit HAS_STATUS = 1'b1,
   parameter bit HAS_IDLE   = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            req_valid_i,
   input  logic            req_on_i,
   input  logic            pwr_stat_i,
   input  logic            idle_ack_i,
   input  logic            idle_stat_i,
   input  logic            qos_done_i,
   input  logic [TO_W-1:0] tmo_limit_i,
   output logic [NCLK-1:0] clk_en_o,
   output logic            idle_req_o,
   output logic            pwr_off_o,
   output logic            qos_save_o,
   output logic            qos_restore_o,
   output logic            busy_o,
   output logic            done_o,
   output logic            err_o
);
   localparam pds_state_e UP_FIRST    = HAS_PWR  ? S_PWR    : (HAS_IDLE ? S_HS_REQ : S_QOS_GO);
   localparam pds_state_e AFTER_SAVE  = HAS_IDLE ? S_HS_REQ : (HAS_PWR  ? S_PWR    : S_CLK_DN);
   localparam pds_state_e AFTER_QUIET = HAS_PWR  ? S_PWR    : S_CLK_DN;
   localparam pds_state_e AFTER_PWRUP = HAS_IDLE ? S_HS_REQ : S_QOS_GO;

   generate
      if (NCLK < 1) begin : g_bad_nclk
         $error("pds_seq: NCLK must be at least 1");
      end
      if (TO_W < 1) begin : g_bad_tow
         $error("pds_seq: TO_W must be at least 1");
      end
      if (!HAS_STATUS && !HAS_IDLE) begin : g_bad_stat
         $error("pds_seq: a domain without status needs the idle handshake");
      end
      if (!HAS_PWR && !HAS_IDLE) begin : g_bad_empty
         $error("pds_seq: a domain needs a power switch or an idle handshake");
      end
   endgenerate

   pds_state_e state_q, nxt;
   logic dir_q, err_q, idle_req_q, pwr_off_q;
   logic on_now, waiting, cond_met, expired;
   logic full, empty, step_up, step_dn;

   generate
      if (HAS_STATUS) begin : g_stat
         assign on_now = !pwr_stat_i;
      end else begin : g_nostat
         assign on_now = !idle_stat_i;
      end
   endgenerate

   assign waiting = (state_q == S_QOS_WAIT) || (state_q == S_HS_ACK) ||
                    (state_q == S_HS_IDL)   || (state_q == S_PWR_WAIT);

   always_comb begin
      unique case (state_q)
         S_QOS_WAIT: cond_met = qos_done_i;
         S_HS_ACK:   cond_met = (idle_ack_i == idle_req_q);
         S_HS_IDL:   cond_met = (idle_stat_i == idle_req_q);
         S_PWR_WAIT: cond_met = (on_now == dir_q);
         default:    cond_met = 1'b0;
      endcase
   end

   always_comb begin
      nxt = state_q;
      unique case (state_q)
         S_IDLE:     if (req_valid_i) nxt = (on_now == req_on_i) ? S_DONE : S_CLK_UP;
         S_CLK_UP:   if (full) nxt = dir_q ? UP_FIRST : S_QOS_GO;
         S_QOS_GO:   nxt = S_QOS_WAIT;
         S_QOS_WAIT: if (cond_met) nxt = dir_q ? S_CLK_DN : AFTER_SAVE;
                     else if (expired) nxt = S_DONE;
         S_HS_REQ:   nxt = S_HS_ACK;
         S_HS_ACK:   if (cond_met) nxt = S_HS_IDL;
                     else if (expired) nxt = S_DONE;
         S_HS_IDL:   if (cond_met) nxt = dir_q ? S_QOS_GO : AFTER_QUIET;
                     else if (expired) nxt = S_DONE;
         S_PWR:      nxt = S_PWR_WAIT;
         S_PWR_WAIT: if (cond_met) nxt = dir_q ? AFTER_PWRUP : S_CLK_DN;
                     else if (expired) nxt = S_DONE;
         S_CLK_DN:   if (empty) nxt = S_DONE;
         S_DONE:     nxt = S_IDLE;
         default:    nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= S_IDLE;
         dir_q      <= 1'b1;
         err_q      <= 1'b0;
         idle_req_q <= 1'b0;
         pwr_off_q  <= 1'b0;
      end else begin
         state_q <= nxt;
         if (state_q == S_IDLE && req_valid_i) begin
            dir_q <= req_on_i;
            err_q <= 1'b0;
         end
         if (waiting && !cond_met && expired) err_q <= 1'b1;
         if (state_q == S_HS_REQ && HAS_IDLE) idle_req_q <= !dir_q;
         if (state_q == S_PWR && HAS_PWR)     pwr_off_q  <= !dir_q;
      end
   end

   assign step_up = (state_q == S_CLK_UP) && !full;
   assign step_dn = (state_q == S_CLK_DN) && !empty;

   pds_clk_chain #(.N(NCLK)) u_chain (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .up_i    (step_up),
      .dn_i    (step_dn),
      .en_o    (clk_en_o),
      .full_o  (full),
      .empty_o (empty)
   );

   pds_wait_timer #(.TO_W(TO_W)) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (nxt != state_q),
      .run_i     (waiting),
      .limit_i   (tmo_limit_i),
      .expired_o (expired)
   );

   assign idle_req_o    = idle_req_q;
   assign pwr_off_o     = pwr_off_q;
   assign qos_save_o    = (state_q == S_QOS_GO) && !dir_q;
   assign qos_restore_o = (state_q == S_QOS_GO) && dir_q;
   assign busy_o        = (state_q != S_IDLE);
   assign done_o        = (state_q == S_DONE);
   assign err_o         = err_q;

   // R2
   save_full_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      qos_save_o |-> (&clk_en_o));

   generate
      if (HAS_IDLE && HAS_PWR) begin : g_hs_chk
         // R2
         off_under_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(pwr_off_o) |-> idle_req_o);
         // R3
         wake_after_pwr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(idle_req_o) |-> !pwr_off_o);
      end
   endgenerate

   // R9
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R8
   err_from_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o) |-> $past(waiting));
endmodule

// File: tb/pds_seq_tb_top.sv
module pds_seq_tb_env (
   input  logic clk,
   input  logic rst_n,
   input  logic hang,
   input  logic pwr_off,
   input  logic idle_req,
   input  logic qos_go,
   output logic pwr_stat,
   output logic idle_ack,
   output logic idle_stat,
   output logic qos_done
);
   logic [1:0] st_pipe, qd_pipe;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_pipe <= '0; qd_pipe <= '0;
         pwr_stat <= 1'b0; idle_ack <= 1'b0; idle_stat <= 1'b0;
      end else begin
         st_pipe <= {st_pipe[0], pwr_off};
         if (!hang) pwr_stat <= st_pipe[1];
         idle_ack  <= idle_req;
         idle_stat <= idle_ack;
         qd_pipe   <= {qd_pipe[0], qos_go};
      end
   end
   assign qos_done = qd_pipe[1];
endmodule

module pds_seq_tb_top;
   localparam int NCLK = 3;
   localparam int TO_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic req_valid = 1'b0, req_on = 1'b0, hang_a = 1'b0;
   logic [TO_W-1:0] tmo = 8'd20;

   logic [NCLK-1:0] ce_a, ce_b, ce_c;
   logic ir_a, ir_b, ir_c, po_a, po_b, po_c;
   logic sv_a, sv_b, sv_c, rs_a, rs_b, rs_c;
   logic bz_a, bz_b, bz_c, dn_a, dn_b, dn_c, er_a, er_b, er_c;
   logic ps_a, ps_b, ps_c, ak_a, ak_b, ak_c, is_a, is_b, is_c, qd_a, qd_b, qd_c;

   pds_seq #(.NCLK(NCLK), .TO_W(TO_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_on_i(req_on),
      .pwr_stat_i(ps_a), .idle_ack_i(ak_a), .idle_stat_i(is_a), .qos_done_i(qd_a),
      .tmo_limit_i(tmo), .clk_en_o(ce_a), .idle_req_o(ir_a), .pwr_off_o(po_a),
      .qos_save_o(sv_a), .qos_restore_o(rs_a), .busy_o(bz_a), .done_o(dn_a), .err_o(er_a));
   pds_seq_tb_env env_a (.clk(clk), .rst_n(rst_n), .hang(hang_a), .pwr_off(po_a),
      .idle_req(ir_a), .qos_go(sv_a | rs_a), .pwr_stat(ps_a), .idle_ack(ak_a),
      .idle_stat(is_a), .qos_done(qd_a));

   pds_seq #(.NCLK(NCLK), .TO_W(TO_W), .HAS_PWR(1'b0), .HAS_STATUS(1'b0)) dut_b (
      .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_on_i(req_on),
      .pwr_stat_i(ps_b), .idle_ack_i(ak_b), .idle_stat_i(is_b), .qos_done_i(qd_b),
      .tmo_limit_i(tmo), .clk_en_o(ce_b), .idle_req_o(ir_b), .pwr_off_o(po_b),
      .qos_save_o(sv_b), .qos_restore_o(rs_b), .busy_o(bz_b), .done_o(dn_b), .err_o(er_b));
   pds_seq_tb_env env_b (.clk(clk), .rst_n(rst_n), .hang(1'b0), .pwr_off(po_b),
      .idle_req(ir_b), .qos_go(sv_b | rs_b), .pwr_stat(ps_b), .idle_ack(ak_b),
      .idle_stat(is_b), .qos_done(qd_b));

   pds_seq #(.NCLK(NCLK), .TO_W(TO_W), .HAS_IDLE(1'b0)) dut_c (
      .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_on_i(req_on),
      .pwr_stat_i(ps_c), .idle_ack_i(ak_c), .idle_stat_i(is_c), .qos_done_i(qd_c),
      .tmo_limit_i(tmo), .clk_en_o(ce_c), .idle_req_o(ir_c), .pwr_off_o(po_c),
      .qos_save_o(sv_c), .qos_restore_o(rs_c), .busy_o(bz_c), .done_o(dn_c), .err_o(er_c));
   pds_seq_tb_env env_c (.clk(clk), .rst_n(rst_n), .hang(1'b0), .pwr_off(po_c),
      .idle_req(ir_c), .qos_go(sv_c | rs_c), .pwr_stat(ps_c), .idle_ack(ak_c),
      .idle_stat(is_c), .qos_done(qd_c));

   int cyc = 0;
   int dc_a = 0, dc_b = 0, dc_c = 0;
   int pb_hi = 0, ic_hi = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (dn_a) dc_a <= dc_a + 1;
      if (dn_b) dc_b <= dc_b + 1;
      if (dn_c) dc_c <= dc_c + 1;
      if (po_b) pb_hi <= pb_hi + 1;
      if (ir_c) ic_hi <= ic_hi + 1;
   end

   // event timestamps for dut_i, plus clock activity of the reduced variants
   int t_c0r = 0, t_c0f = 0, t_cNr = 0, t_cNf = 0, t_sv = 0, t_rs = 0;
   int t_irr = 0, t_irf = 0, t_akr = 0, t_akf = 0, t_isr = 0, t_isf = 0;
   int t_por = 0, t_pof = 0, t_str = 0, t_stf = 0, t_bclk = 0, t_cclk = 0;
   logic [NCLK-1:0] p_ce = '0;
   logic p_ir = 0, p_ak = 0, p_is = 0, p_po = 0, p_ps = 0;
   always @(negedge clk) begin
      if (ce_a[0] && !p_ce[0]) t_c0r = cyc;
      if (!ce_a[0] && p_ce[0]) t_c0f = cyc;
      if (ce_a[NCLK-1] && !p_ce[NCLK-1]) t_cNr = cyc;
      if (!ce_a[NCLK-1] && p_ce[NCLK-1]) t_cNf = cyc;
      if (sv_a) t_sv = cyc;
      if (rs_a) t_rs = cyc;
      if (ir_a != p_ir) begin if (ir_a) t_irr = cyc; else t_irf = cyc; end
      if (ak_a != p_ak) begin if (ak_a) t_akr = cyc; else t_akf = cyc; end
      if (is_a != p_is) begin if (is_a) t_isr = cyc; else t_isf = cyc; end
      if (po_a != p_po) begin if (po_a) t_por = cyc; else t_pof = cyc; end
      if (ps_a != p_ps) begin if (ps_a) t_str = cyc; else t_stf = cyc; end
      if (ce_b != '0) t_bclk = cyc;
      if (ce_c != '0) t_cclk = cyc;
      p_ce = ce_a; p_ir = ir_a; p_ak = ak_a; p_is = is_a; p_po = po_a; p_ps = ps_a;
   end

   int n_tests = 0, n_fail = 0;
   int t_issue = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic after(input string req, input string what, input int later, input int earlier);
      check(later > earlier, req, what, later, earlier + 1);
   endtask

   task automatic pulse_req(input logic on);
      @(negedge clk);
      req_valid = 1'b1; req_on = on; t_issue = cyc;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done(input int sa, input int sb, input int sc);
      for (int k = 0; k < 300; k++) begin
         if (dc_a > sa && dc_b > sb && dc_c > sc) break;
         @(negedge clk);
      end
      @(negedge clk);
      check(dc_a == sa + 1 && dc_b == sb + 1 && dc_c == sc + 1, "R9", "one done per request",
            dc_a - sa, 1);
   endtask

   task automatic check_level(input string req, input logic on);
      check(ps_a == !on, "R4", {req, " status a"}, ps_a, !on);
      check(is_b == !on, "R5", {req, " idle-as-status b"}, is_b, !on);
      check(ps_c == !on, "R4", {req, " status c"}, ps_c, !on);
   endtask

   // {req_on, expect_noop}
   localparam logic [1:0] VEC [0:5] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b00, 2'b10};

   initial begin
      #(8 * 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11
      check(ce_a == '0 && ce_b == '0 && ce_c == '0, "R11", "reset clk enables", ce_a, 0);
      check(!ir_a && !po_a && !bz_a && !dn_a && !er_a, "R11", "reset controls",
            {ir_a, po_a, bz_a, dn_a, er_a}, 0);

      foreach (VEC[v]) begin
         logic on, noop;
         int sa, sb, sc;
         on = VEC[v][1]; noop = VEC[v][0];
         sa = dc_a; sb = dc_b; sc = dc_c;
         pulse_req(on);
         wait_done(sa, sb, sc);
         check_level("table", on);
         check(po_a == !on, "R4", "power control level", po_a, !on);
         check(ce_a == '0 && ce_b == '0 && ce_c == '0, "R7", "clocks released", ce_a, 0);
         check(!er_a && !er_b && !er_c, "R8", "no error", er_a, 0);
         check(!bz_a, "R9", "idle after done", bz_a, 0);
         if (noop) begin
            check(t_c0r < t_issue && t_bclk < t_issue && t_cclk < t_issue, "R1",
                  "no clocks on no-op", t_c0r, t_issue - 1);
         end else if (!on) begin
            after("R7", "clk0 before clkN on", t_cNr, t_c0r);
            after("R2", "save after clocks", t_sv, t_cNr);
            after("R2", "idle req after save", t_irr, t_sv);
            after("R2", "ack after req", t_akr, t_irr);
            after("R2", "idle after ack", t_isr, t_akr);
            after("R2", "power off after idle", t_por, t_isr);
            after("R2", "status after switch", t_str, t_por);
            after("R2", "release after status", t_cNf, t_str);
            after("R7", "clk0 released last", t_c0f, t_cNf);
         end else begin
            after("R3", "switch on after clocks", t_pof, t_cNr);
            after("R3", "status after switch", t_stf, t_pof);
            after("R3", "idle req drop after status", t_irf, t_stf);
            after("R3", "ack drop after req", t_akf, t_irf);
            after("R3", "idle clear after ack", t_isf, t_akf);
            after("R3", "restore after idle clear", t_rs, t_isf);
            after("R3", "release after restore", t_cNf, t_rs);
            after("R7", "clk0 released last", t_c0f, t_cNf);
         end
      end
      // R6
      check(pb_hi == 0, "R6", "no-switch variant power control", pb_hi, 0);
      check(ic_hi == 0, "R6", "no-handshake variant idle request", ic_hi, 0);

      // R9: a request while busy is dropped
      begin
         int sa, sb, sc;
         sa = dc_a; sb = dc_b; sc = dc_c;
         pulse_req(1'b0);
         repeat (2) @(negedge clk);
         check(bz_a, "R9", "busy during run", bz_a, 1);
         req_valid = 1'b1; req_on = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
         wait_done(sa, sb, sc);
         repeat (30) @(negedge clk);
         check(dc_a == sa + 1, "R9", "dropped request made no run", dc_a - sa, 1);
         check_level("busy drop", 1'b0);
         sa = dc_a; sb = dc_b; sc = dc_c;
         pulse_req(1'b1);
         wait_done(sa, sb, sc);
         check_level("restore on", 1'b1);
      end

      // R8 / R10: stuck status causes a timeout
      begin
         int sa, sb, sc;
         logic [NCLK-1:0] ce_snap;
         tmo = 8'd6; hang_a = 1'b1;
         sa = dc_a; sb = dc_b; sc = dc_c;
         pulse_req(1'b0);
         wait_done(sa, sb, sc);
         check(er_a, "R8", "error on timeout", er_a, 1);
         check(!er_b && !er_c, "R8", "no error for healthy domains", er_b, 0);
         check(ce_a == '1, "R8", "clocks left enabled", ce_a, '1);
         check(po_a && ir_a, "R8", "controls left asserted", {po_a, ir_a}, 3);
         ce_snap = ce_a;
         repeat (20) @(negedge clk);
         check(ce_a == ce_snap && !bz_a, "R8", "no further steps", ce_a, ce_snap);
         hang_a = 1'b0;
         repeat (10) @(negedge clk);
         check(ps_a, "R4", "status reads off once released", ps_a, 1);
         sa = dc_a; sb = dc_b; sc = dc_c;
         pulse_req(1'b1);
         repeat (2) @(negedge clk);
         check(!er_a, "R10", "error cleared on accept", er_a, 0);
         wait_done(sa, sb, sc);
         check_level("recovery", 1'b1);
         check(ce_a == '0 && !er_a, "R10", "clean finish after recovery", ce_a, 0);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule